// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 16-bit effective address of one memory operand from a mode code, two register-file read values, the program counter, a signed displacement carried by the instruction and a scale code. One shared adder serves every register-relative mode. The supported modes are indexed, base plus displacement, scaled index, base plus index plus displacement and PC-relative. It also supports two self-updating pointer modes. In those modes the block also returns the updated register value with a write strobe, so the register file can store it back.

The block drives the two register selectors straight from its base and index select inputs, and it reads the register values back in the same cycle. Register 0 is treated as a constant zero whatever the register file returns. A single output register stage holds the result, and a new operand can be accepted on every clock.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (indexed) gives EA = R[idxSel] + sign-extended disp. With disp = 0 the result equals R[idxSel], which is plain register-indirect addressing.
- R2: The displacement is an 8-bit two's complement value, sign-extended to 16 bits before the add. All arithmetic wraps modulo 2^16.
- R3: Mode code 2 (scaled index) gives EA = (R[idxSel] << scale) + sign-extended disp. Scale codes 0, 1, 2 and 3 give factors of 1, 2, 4 and 8.
- R4: Register 0 always reads as zero. In mode code 1 (base), EA = R[baseSel] + sign-extended disp, so with baseSel = 0 the EA equals the sign-extended displacement (absolute addressing).
- R5: Mode code 3 (base plus index) gives EA = R[baseSel] + R[idxSel] + sign-extended disp.
- R6: Mode code 4 (PC-relative) gives EA = pcVal + sign-extended disp.
- R7: Mode code 5 (pre-decrement) computes R[idxSel] − step. That value is both the EA and wbData, and wbEn is high with wbSel = idxSel. The displacement is not used.
- R8: Mode code 6 (post-increment) gives EA = R[idxSel] (the value before the update), with wbData = R[idxSel] + step, wbEn high and wbSel = idxSel.
- R9: The step is 1 when sizeWord = 0 and 2 when sizeWord = 1.
- R10: Modes 0 to 4 never raise wbEn.
- R11: Mode code 7 is undefined. It raises errOut with outValid and keeps wbEn low.
- R12: outValid, eaOut, wbEn, wbData and errOut appear one clock after the input is accepted (inValid high). When inValid is low, the next cycle has outValid, wbEn and errOut low. Reset clears outValid, wbEn and errOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand request present this cycle |
| mode | input | 3 | Addressing mode code |
| scale | input | 2 | Index scale code (shift 0..3) |
| sizeWord | input | 1 | Auto step size: 0 gives 1, 1 gives 2 |
| baseSel | input | 3 | Base register number |
| idxSel | input | 3 | Index register number |
| disp | input | 8 | Two's complement displacement |
| pcVal | input | 16 | Current program counter |
| rdSelA | output | 3 | Register-file read select A (base) |
| rdSelB | output | 3 | Register-file read select B (index) |
| rdDataA | input | 16 | Register-file read data A |
| rdDataB | input | 16 | Register-file read data B |
| outValid | output | 1 | Result present |
| eaOut | output | 16 | Effective address |
| wbEn | output | 1 | Register write-back strobe |
| wbSel | output | 3 | Register number to write |
| wbData | output | 16 | Updated register value |
| errOut | output | 1 | Undefined mode seen |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit displacement and eight registers. With only eight registers, random selection picks register 0 for base or index often. This exercises the constant-zero rule in every mode without extra directed work. The 8-bit displacement lets random values cover negative offsets and wrap past 0x0000 and 0xFFFF often. A nonzero value is placed behind register 0 in the bench's register model, so any leak of the raw read data shows up in the address.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;

  typedef enum logic [2:0] {
    MODE_IDX     = 3'd0,
    MODE_BASE    = 3'd1,
    MODE_SCALED  = 3'd2,
    MODE_BASEIDX = 3'd3,
    MODE_PCREL   = 3'd4,
    MODE_PREDEC  = 3'd5,
    MODE_POSTINC = 3'd6
  } eaMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic useBase;
    logic useIdx;
    logic usePc;
    logic scaleEn;
    logic addDisp;
    logic preDec;
    logic postInc;
    logic wbReq;
    logic err;
  } eaStrobes_t;

endpackage

// File: rtl/ea_ctrl.sv
`timescale 1ns/1ps
module ea_ctrl
  import ea_pkg::*;
(
  input  logic [2:0]  mode,
  output eaStrobes_t  strb
);

  always_comb begin
    strb = '0;
    case (mode)
      MODE_IDX: begin
        strb.useIdx  = 1'b1;
        strb.addDisp = 1'b1;
      end
      MODE_BASE: begin
        strb.useBase = 1'b1;
        strb.addDisp = 1'b1;
      end
      MODE_SCALED: begin
        strb.useIdx  = 1'b1;
        strb.scaleEn = 1'b1;
        strb.addDisp = 1'b1;
      end
      MODE_BASEIDX: begin
        strb.useBase = 1'b1;
        strb.useIdx  = 1'b1;
        strb.addDisp = 1'b1;
      end
      MODE_PCREL: begin
        strb.usePc   = 1'b1;
        strb.addDisp = 1'b1;
      end
      MODE_PREDEC: begin
        strb.preDec = 1'b1;
        strb.wbReq  = 1'b1;
      end
      MODE_POSTINC: begin
        strb.postInc = 1'b1;
        strb.wbReq   = 1'b1;
      end
      default: strb.err = 1'b1;  // R11 undefined code
    endcase
  end

  // R10 / R11: only the two pointer modes request write-back, never with error
  always_comb begin
    a_wb_modes_r10: assert (!strb.wbReq || mode == MODE_PREDEC || mode == MODE_POSTINC);
    a_err_nowb_r11: assert (!(strb.err && strb.wbReq));
  end

endmodule

// File: rtl/ea_datapath.sv
`timescale 1ns/1ps
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  eaStrobes_t        strb,
  input  logic [1:0]        scale,
  input  logic              sizeWord,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [SEL_W-1:0]  idxSel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [ADDR_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdDataB,
  output logic              outValid,
  output logic [ADDR_W-1:0] eaOut,
  output logic              wbEn,
  output logic [SEL_W-1:0]  wbSel,
  output logic [ADDR_W-1:0] wbData,
  output logic              errOut
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] baseOp, idxOp, dispExt, scaledIdx;
  logic [ADDR_W-1:0] opA, opB, opD, sum, step, incVal, decVal, eaNext, wbNext;

  // R4: register 0 is a hard zero
  assign baseOp  = (baseSel == '0) ? '0 : rdDataA;
  assign idxOp   = (idxSel  == '0) ? '0 : rdDataB;
  // R2: sign extension
  assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
  // R3: scale by shift
  assign scaledIdx = strb.scaleEn ? (idxOp << scale) : idxOp;

  assign opA = strb.usePc ? pcVal : (strb.useBase ? baseOp : '0);
  assign opB = strb.useIdx  ? scaledIdx : '0;
  assign opD = strb.addDisp ? dispExt   : '0;
  assign sum = opA + opB + opD;

  // R9: step size
  assign step   = sizeWord ? ADDR_W'(2) : ADDR_W'(1);
  assign incVal = idxOp + step;
  assign decVal = idxOp - step;

  always_comb begin
    if (strb.preDec)       eaNext = decVal;
    else if (strb.postInc) eaNext = idxOp;
    else                   eaNext = sum;
  end
  assign wbNext = strb.preDec ? decVal : incVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wbEn     <= 1'b0;
      errOut   <= 1'b0;
      eaOut    <= '0;
      wbData   <= '0;
      wbSel    <= '0;
    end else begin
      outValid <= inValid;
      wbEn     <= inValid && strb.wbReq && !strb.err;
      errOut   <= inValid && strb.err;
      if (inValid) begin
        eaOut  <= eaNext;
        wbData <= wbNext;
        wbSel  <= idxSel;
      end
    end
  end

  p_latency_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid == $past(inValid));
  p_wb_needs_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn || errOut) |-> outValid);
  p_no_wb_plain_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strb.preDec && !strb.postInc) |=> !wbEn);
  p_err_nowb_r11: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> !wbEn);
  p_predec_same_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.preDec) |=> (eaOut == wbData) && wbEn);
  p_postinc_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.postInc) |=> (wbData - eaOut) == $past(step));

endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        mode,
  input  logic [1:0]        scale,
  input  logic              sizeWord,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [SEL_W-1:0]  idxSel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] pcVal,
  output logic [SEL_W-1:0]  rdSelA,
  output logic [SEL_W-1:0]  rdSelB,
  input  logic [ADDR_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdDataB,
  output logic              outValid,
  output logic [ADDR_W-1:0] eaOut,
  output logic              wbEn,
  output logic [SEL_W-1:0]  wbSel,
  output logic [ADDR_W-1:0] wbData,
  output logic              errOut
);

  eaStrobes_t strb;

  assign rdSelA = baseSel;
  assign rdSelB = idxSel;

  ea_ctrl uCtrl (
    .mode (mode),
    .strb (strb)
  );

  ea_datapath #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .SEL_W  (SEL_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .scale    (scale),
    .sizeWord (sizeWord),
    .baseSel  (baseSel),
    .idxSel   (idxSel),
    .disp     (disp),
    .pcVal    (pcVal),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .outValid (outValid),
    .eaOut    (eaOut),
    .wbEn     (wbEn),
    .wbSel    (wbSel),
    .wbData   (wbData),
    .errOut   (errOut)
  );

endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  scale = '0;
  logic        sizeWord = 1'b0;
  logic [2:0]  baseSel = '0, idxSel = '0;
  logic [7:0]  disp = '0;
  logic [15:0] pcVal = '0;
  logic [2:0]  rdSelA, rdSelB, wbSel;
  logic [15:0] rdDataA, rdDataB, eaOut, wbData;
  logic        outValid, wbEn, errOut;
  logic [15:0] regs [8];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  assign rdDataA = regs[rdSelA];
  assign rdDataB = regs[rdSelB];

  ea_gen uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .scale(scale),
    .sizeWord(sizeWord), .baseSel(baseSel), .idxSel(idxSel), .disp(disp),
    .pcVal(pcVal), .rdSelA(rdSelA), .rdSelB(rdSelB), .rdDataA(rdDataA),
    .rdDataB(rdDataB), .outValid(outValid), .eaOut(eaOut), .wbEn(wbEn),
    .wbSel(wbSel), .wbData(wbData), .errOut(errOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rv(input logic [2:0] s);
    return (s == 3'd0) ? 16'h0000 : regs[s];
  endfunction

  function automatic string reqOf(input logic [2:0] m);
    case (m)
      3'd0: return "R1 indexed";
      3'd1: return "R4 base";
      3'd2: return "R3 scaled";
      3'd3: return "R5 base+index";
      3'd4: return "R6 pc-relative";
      3'd5: return "R7 pre-decrement";
      3'd6: return "R8 post-increment";
      default: return "R11 undefined";
    endcase
  endfunction

  task automatic runOp(input logic [2:0] m, input logic [1:0] sc, input logic sz,
                       input logic [2:0] b, input logic [2:0] i, input logic [7:0] d,
                       input logic [15:0] pc);
    logic [15:0] dx, st, expEa, expWb;
    bit expWbEn, expErr;
    dx = {{8{d[7]}}, d};
    st = sz ? 16'd2 : 16'd1;
    expWb = 16'h0; expWbEn = 0; expErr = 0;
    case (m)
      3'd0: expEa = rv(i) + dx;
      3'd1: expEa = rv(b) + dx;
      3'd2: expEa = (rv(i) << sc) + dx;
      3'd3: expEa = rv(b) + rv(i) + dx;
      3'd4: expEa = pc + dx;
      3'd5: begin expEa = rv(i) - st; expWb = expEa; expWbEn = 1; end
      3'd6: begin expEa = rv(i); expWb = rv(i) + st; expWbEn = 1; end
      default: begin expEa = 16'h0; expErr = 1; end
    endcase
    @(negedge clk);
    inValid = 1; mode = m; scale = sc; sizeWord = sz;
    baseSel = b; idxSel = i; disp = d; pcVal = pc;
    @(posedge clk);
    #1;
    inValid = 0;
    chk(outValid == 1'b1, {"R12 valid ", reqOf(m)}, 32'(outValid), 32'd1);
    chk(wbEn == expWbEn, {"R10 wbEn ", reqOf(m)}, 32'(wbEn), 32'(expWbEn));
    chk(errOut == expErr, {"R11 err ", reqOf(m)}, 32'(errOut), 32'(expErr));
    if (!expErr)
      chk(eaOut == expEa, {"R2 ea ", reqOf(m)}, 32'(eaOut), 32'(expEa));
    if (expWbEn) begin
      chk(wbData == expWb, {"R9 wbData ", reqOf(m)}, 32'(wbData), 32'(expWb));
      chk(wbSel == i, {"wbSel ", reqOf(m)}, 32'(wbSel), 32'(i));
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    regs[0] = 16'hBEEF;  // must never leak (R4)
    regs[1] = 16'h1000; regs[2] = 16'hFFFE; regs[3] = 16'h0003;
    regs[4] = 16'h8000; regs[5] = 16'h0001; regs[6] = 16'h7FFF; regs[7] = 16'h2345;
    repeat (3) @(posedge clk);
    #1;
    chk(outValid == 0 && wbEn == 0 && errOut == 0, "R12 reset", {29'd0, outValid, wbEn, errOut}, 32'd0);
    @(negedge clk); rstN = 1;

    // directed corners
    runOp(3'd0, 2'd0, 0, 3'd0, 3'd1, 8'h00, 16'h0);     // R1 register-indirect
    runOp(3'd0, 2'd0, 0, 3'd0, 3'd1, 8'hF0, 16'h0);     // R2 negative disp
    runOp(3'd0, 2'd0, 0, 3'd0, 3'd2, 8'h05, 16'h0);     // R2 wrap past FFFF
    for (int s = 0; s < 4; s++) runOp(3'd2, 2'(s), 0, 3'd0, 3'd3, 8'h01, 16'h0); // R3
    runOp(3'd2, 2'd3, 0, 3'd0, 3'd4, 8'h00, 16'h0);     // R3 shift out top
    runOp(3'd1, 2'd0, 0, 3'd0, 3'd5, 8'h80, 16'h0);     // R4 absolute via reg0
    runOp(3'd1, 2'd0, 0, 3'd7, 3'd0, 8'h10, 16'h0);     // R4 base
    runOp(3'd0, 2'd0, 0, 3'd7, 3'd0, 8'h10, 16'h0);     // R4 index reg0
    runOp(3'd3, 2'd0, 0, 3'd1, 3'd7, 8'hFF, 16'h0);     // R5
    runOp(3'd4, 2'd0, 0, 3'd1, 3'd1, 8'h80, 16'h0040);  // R6 wrap below zero
    runOp(3'd5, 2'd0, 0, 3'd0, 3'd5, 8'h33, 16'h0);     // R7 step 1
    runOp(3'd5, 2'd0, 1, 3'd0, 3'd0, 8'h00, 16'h0);     // R7 from zero wraps, R9
    runOp(3'd6, 2'd0, 1, 3'd0, 3'd6, 8'h44, 16'h0);     // R8 step 2
    runOp(3'd6, 2'd0, 0, 3'd0, 3'd2, 8'h00, 16'h0);     // R8 R9
    runOp(3'd7, 2'd0, 0, 3'd1, 3'd1, 8'h00, 16'h0);     // R11

    // R12 idle cycle clears strobes
    @(negedge clk);
    @(posedge clk); #1;
    chk(outValid == 0 && wbEn == 0 && errOut == 0, "R12 idle", {29'd0, outValid, wbEn, errOut}, 32'd0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      if (n % 16 == 0)
        for (int r = 1; r < 8; r++) regs[r] = 16'($urandom);
      runOp(3'($urandom), 2'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
            8'($urandom), 16'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule